// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block produces the address for each beat of a four-beat burst into a synchronous pipelined SRAM of 512K words by 36 bits. It has a 19-bit word address. A load strobe captures a full starting address and the burst ordering. Each later advance strobe steps to the next beat. Through the whole burst only the two lowest address bits move. The upper seventeen bits keep the value that was captured at load.

Two orderings are supported. In linear ordering the low bits count up from the start, modulo four. In interleaved ordering each beat's low bits are the start bits XORed with the beat index. Both orderings stay inside the aligned group of four words. An advance on the final beat returns to the starting address, and the sequence repeats. A flag marks the fourth beat, so the controller that drives the memory knows when a burst is complete.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, addr_o is 0 and last_o is 0.
- R2: After a clock edge with load_i high, addr_o equals the addr_i value captured at that edge, and the beat index is 0 (last_o low).
- R3: When load_i and adv_i are both high at the same edge, the load wins: addr_o shows the new start address and last_o is low.
- R4: With linear ordering (mode_i = 0 at load), each advance raises addr_o[1:0] by one, modulo 4. A start of 2'b10 gives 10, 11, 00, 01.
- R5: With interleaved ordering (mode_i = 1 at load), beat k presents start[1:0] XOR k. A start of 2'b01 gives 01, 00, 11, 10, and a start of 2'b11 gives 11, 10, 01, 00.
- R6: addr_o[18:2] equals the loaded addr_i[18:2] on every beat of a burst.
- R7: last_o is high exactly while the burst sits on its fourth beat (beat index 3).
- R8: An advance on the fourth beat wraps back to the start address (beat index 0), and the sequence repeats.
- R9: mode_i is sampled only at a load. Changing mode_i during a burst has no effect on the sequence.
- R10: In a cycle with neither load_i nor adv_i, addr_o and last_o hold their values.
- R11: A start of 2'b00 gives 00, 01, 10, 11 in both orderings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture a start address and ordering, and restart at beat 0 |
| addr_i | input | 19 | Starting word address |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Burst ordering: 0 = linear, 1 = interleaved |
| addr_o | output | 19 | Word address of the current beat |
| last_o | output | 1 | High on the fourth beat |

## Verification
The case that is hardest to reach is a change of ordering or a new load while a burst is in flight. Examples are a load that lands on the same edge as an advance, a load during the fourth beat, and mode_i flipping between advances. Directed sequences create each of these collisions on purpose. A long pseudo-random phase then drives load, advance and mode independently. This produces wraps, back-to-back loads and idle gaps in every combination. A behavioural model in the bench checks every cycle of it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] idx_o,
  output logic              final_o
);
  logic [BEAT_W-1:0] idx_q;

  // clear has priority over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o   = idx_q;
  assign final_o = &idx_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] idx_i,
  input  burst_ord_e        ord_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low, xor_low;

  assign lin_low = start_i + idx_i;  // wraps within aligned group
  assign xor_low = start_i ^ idx_i;

  always_comb begin
    unique case (ord_i)
      ORD_XOR: low_o = xor_low;
      default: low_o = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] base_q;
  burst_ord_e        mode_q;
  logic [BEAT_W-1:0] idx;
  logic [BEAT_W-1:0] low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mode_q <= ORD_LINEAR;
    end else if (load_i) begin
      base_q <= addr_i;
      mode_q <= burst_ord_e'(mode_i);
    end
  end

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .step_i (adv_i),
    .idx_o  (idx),
    .final_o(last_o)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i(base_q[BEAT_W-1:0]),
    .idx_i  (idx),
    .ord_i  (mode_q),
    .low_o  (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o,
  input logic [ADDR_W-1:0] base_q,
  input burst_ord_e        mode_q
);
  // R2
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(addr_i)) && !last_o);

  // R6
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R8
  wrap_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && last_o) |=> !last_o && (addr_o == base_q));

  // R4
  lin_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mode_q == ORD_LINEAR)
      |=> addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1);

  // R5
  xor_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && mode_q == ORD_XOR)
      |=> (addr_o[BEAT_W-1:0] ^ base_q[BEAT_W-1:0]) ==
          ($past(addr_o[BEAT_W-1:0] ^ base_q[BEAT_W-1:0]) + 1'b1));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(addr_o) && $stable(last_o));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .load_i(load_i),
  .adv_i (adv_i),
  .addr_i(addr_i),
  .addr_o(addr_o),
  .last_o(last_o),
  .base_q(base_q),
  .mode_q(mode_q)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [18:0] addr_i = '0;
  logic        adv_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [18:0] addr_o;
  logic        last_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag     = "R1";
  bit    done    = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_seq dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .addr_i(addr_i),
    .adv_i (adv_i),
    .mode_i(mode_i),
    .addr_o(addr_o),
    .last_o(last_o)
  );

  // behavioural reference
  int m_base = 0;
  int m_beat = 0;
  bit m_xor  = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_base = 0; m_beat = 0; m_xor = 1'b0;
    end else if (load_i) begin
      m_base = int'(addr_i); m_beat = 0; m_xor = mode_i;
    end else if (adv_i) begin
      m_beat = (m_beat + 1) % 4;
    end
  end

  function automatic int model_addr();
    int lo;
    lo = m_xor ? ((m_base % 4) ^ m_beat) : (((m_base % 4) + m_beat) % 4);
    return (m_base - (m_base % 4)) + lo;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      chk(int'(addr_o), model_addr(), {tag, " addr_o"});
      chk(int'(last_o), (m_beat == 3) ? 1 : 0, {tag, " last_o"});
    end
  end

  task automatic tick(input bit ld, input int a, input bit av, input bit md, input string t);
    tag = t; load_i = ld; addr_i = a[18:0]; adv_i = av; mode_i = md;
    @(negedge clk_i);
  endtask

  task automatic burst_expect(input int lows[4], input string t);
    for (int k = 1; k < 4; k++) begin
      tick(1'b0, 0, 1'b1, 1'b0, t);
      chk(int'(addr_o[1:0]), lows[k], {t, " beat low"});
    end
    chk(int'(last_o), 1, "R7 fourth beat flag");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk_i);
    chk(int'(addr_o), 0, "R1 reset addr");
    chk(int'(last_o), 0, "R1 reset last");
    rst_ni = 1'b1;
    tick(1'b0, 0, 1'b0, 1'b0, "R1");
    chk(int'(addr_o), 0, "R1 post-reset addr");

    // R2 + R4: linear from 10
    tick(1'b1, 'h5A5A6, 1'b0, 1'b0, "R2");
    chk(int'(addr_o), 'h5A5A6, "R2 load addr");
    chk(int'(last_o), 0, "R2 load last");
    burst_expect('{2, 3, 0, 1}, "R4");
    chk(int'(addr_o[18:2]), 'h5A5A6 >> 2, "R6 upper bits");
    // R8 wrap
    tick(1'b0, 0, 1'b1, 1'b0, "R8");
    chk(int'(addr_o), 'h5A5A6, "R8 wrap addr");
    chk(int'(last_o), 0, "R8 wrap last");
    burst_expect('{2, 3, 0, 1}, "R8");

    // R5 interleaved
    tick(1'b1, 'h12341, 1'b0, 1'b1, "R5");
    chk(int'(addr_o[1:0]), 1, "R5 start 01");
    burst_expect('{1, 0, 3, 2}, "R5");
    tick(1'b1, 'h7FFFF, 1'b0, 1'b1, "R5");
    burst_expect('{3, 2, 1, 0}, "R5");
    chk(int'(addr_o[18:2]), 'h7FFFF >> 2, "R6 upper bits xor");

    // R11 start 00 both orderings
    tick(1'b1, 'h40000, 1'b0, 1'b0, "R11");
    burst_expect('{0, 1, 2, 3}, "R11");
    tick(1'b1, 'h40000, 1'b0, 1'b1, "R11");
    burst_expect('{0, 1, 2, 3}, "R11");

    // R3 load + advance same edge, including during fourth beat
    tick(1'b1, 'h00003, 1'b1, 1'b0, "R3");
    chk(int'(addr_o), 3, "R3 load wins addr");
    chk(int'(last_o), 0, "R3 load wins last");
    tick(1'b0, 0, 1'b1, 1'b0, "R3");
    tick(1'b0, 0, 1'b1, 1'b0, "R3");
    tick(1'b0, 0, 1'b1, 1'b0, "R3");
    tick(1'b1, 'h2AAA9, 1'b1, 1'b1, "R3");
    chk(int'(addr_o), 'h2AAA9, "R3 load on fourth beat");

    // R9 mode flip mid-burst ignored
    tick(1'b1, 'h00101, 1'b0, 1'b0, "R9");
    tick(1'b0, 0, 1'b1, 1'b1, "R9");
    chk(int'(addr_o[1:0]), 2, "R9 linear kept");
    tick(1'b0, 0, 1'b1, 1'b1, "R9");
    chk(int'(addr_o[1:0]), 3, "R9 linear kept");

    // R10 idle hold with mode toggling
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 'h7FFFF, 1'b0, i[0], "R10");
      chk(int'(addr_o), 'h00103, "R10 hold addr");
    end

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      tick(r[3:0] == 0, int'($urandom) & 'h7FFFF, r[5:4] != 0, r[6], "R8");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule